// File: doc/BRIEF.md
# Programmable Memory and I/O Chip Select Decoder

This block turns each bus cycle into at most one active-low chip select for an external device. Four channels watch a 24-bit address and two cycle strobes: one for memory requests and one for I/O requests. Each channel has its own configuration: an enable flag, a type flag and two 8-bit bounds.

A memory-type channel claims a memory cycle when the top address byte lies between its two bounds, both bounds included. An I/O-type channel claims an I/O cycle when the middle address byte equals its lower bound. I/O cycles that fall in the internal peripheral window, 16-bit addresses 0080h through 00FFh, are never passed to a chip select. When several channels qualify, only the lowest-numbered one asserts. The select lines are registered, so they follow the cycle inputs by one clock.

Software or a boot sequencer sets up the channels through a small write port. The port takes a channel number, a field selector and a data byte.

Top module: `chip_sel_dec`

## Requirements
- R1: After reset, all selects are high (1) while no strobe is active. Channel 0 is enabled as a memory channel with bounds 00h..FFh, so any memory cycle selects channel 0 (cs_n = 4'b1110). Channels 1 to 3 come out of reset disabled.
- R2: A channel whose enable flag is 0 never drives its select low.
- R3: A memory-type channel (type flag 0) matches a cycle with mem_req=1 when lower bound <= addr[23:16] <= upper bound. Both ends are inclusive; an address one step outside either bound does not match.
- R4: An I/O-type channel (type flag 1) matches a cycle with io_req=1 when addr[15:8] equals its lower bound. addr[23:16] and the upper bound play no part in this match.
- R5: An I/O-type channel never responds while io_req=0. A memory-type channel never responds while mem_req=0.
- R6: When several channels match, only the lowest-numbered one drives its select low. At most one select is low in any cycle.
- R7: No I/O-type channel asserts while addr[15:0] is between 0080h and 00FFh inclusive. This holds whatever addr[23:16] is.
- R8: cs_n reflects the inputs sampled at the previous rising clock edge. A change of address or strobe between edges does not move cs_n.
- R9: Configuration writes take cfg_addr = {channel[1:0], field[1:0]}. The fields are:
  - field 0: control byte, where bit0 is the enable flag and bit1 is the type flag (1 = I/O);
  - field 1: lower bound;
  - field 2: upper bound.

  Field 3 is unused, and a write to it changes no channel's behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 24 | Bus address of the current cycle |
| mem_req | input | 1 | Memory cycle strobe, active high |
| io_req | input | 1 | I/O cycle strobe, active high |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Channel number (bits 3:2) and field selector (bits 1:0) |
| cfg_wdata | input | 8 | Configuration write data |
| cs_n | output | 4 | Chip selects, active low, one bit per channel |

## Verification
The bench probes each memory bound exactly at its edge and one step beyond it. A comparator written with the wrong strictness would lose the first or last 64 KB page of a range, or claim the page next to it.

It also lines up I/O cycles against overlapping channels, against the peripheral window edges 007Fh, 0080h, 00FFh and 0100h, and against the wrong strobe. A wrong priority chain would show two selects low or the wrong one. An off-by-one window check would hide a valid device, and a missing strobe qualifier would let an I/O device answer memory cycles.

Writes to the unused field and a mid-cycle check of the select lines catch a loose field decoder and a select path that has lost its register.

// File: rtl/csd_pkg.sv
package csd_pkg;

  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              en;
    logic              io;
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    FLD_CTRL  = 2'd0,
    FLD_LO    = 2'd1,
    FLD_HI    = 2'd2,
    FLD_SPARE = 2'd3
  } cfg_field_e;

  // inclusive range test on the top address byte
  function automatic logic range_match(input chan_cfg_t c, input logic [BYTE_W-1:0] top);
    return (top >= c.lo) && (top <= c.hi);
  endfunction

  // exact compare of the middle address byte
  function automatic logic port_match(input chan_cfg_t c, input logic [BYTE_W-1:0] mid);
    return mid == c.lo;
  endfunction

  // internal peripheral I/O window 0080h..00FFh
  function automatic logic in_periph_window(input logic [15:0] a16);
    return (a16 >= 16'h0080) && (a16 <= 16'h00FF);
  endfunction

endpackage

// File: rtl/csd_cfg_regs.sv
module csd_cfg_regs
  import csd_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = CHW + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [BYTE_W-1:0]     wdata,
  output chan_cfg_t             cfg [NCH]
);

  logic [CHW-1:0] wr_ch;
  cfg_field_e     wr_fld;

  assign wr_ch  = waddr[AW-1:2];
  assign wr_fld = cfg_field_e'(waddr[1:0]);

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    localparam chan_cfg_t RST = (i == 0) ? chan_cfg_t'{en: 1'b1, io: 1'b0, lo: 8'h00, hi: 8'hFF}
                                         : chan_cfg_t'{en: 1'b0, io: 1'b0, lo: 8'h00, hi: 8'h00};
    logic sel;
    assign sel = we && (wr_ch == CHW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[i] <= RST;
      end else if (sel) begin
        case (wr_fld)
          FLD_CTRL: begin
            cfg[i].en <= wdata[0];
            cfg[i].io <= wdata[1];
          end
          FLD_LO:  cfg[i].lo <= wdata;
          FLD_HI:  cfg[i].hi <= wdata;
          default: ;
        endcase
      end
    end

    // R9
    spare_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wr_fld == FLD_SPARE) |=> $stable(cfg[i]));
  end

endmodule

// File: rtl/csd_chan_match.sv
module csd_chan_match
  import csd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chan_cfg_t         cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_req,
  input  logic              io_req,
  input  logic              periph_hit,
  output logic              hit
);

  logic [BYTE_W-1:0] top_byte;
  logic [BYTE_W-1:0] mid_byte;
  logic              mem_side;
  logic              io_side;

  assign top_byte = addr[ADDR_W-1 -: BYTE_W];
  assign mid_byte = addr[15:8];

  assign mem_side = !cfg.io && mem_req && range_match(cfg, top_byte);
  assign io_side  =  cfg.io && io_req && !periph_hit && port_match(cfg, mid_byte);
  assign hit      = cfg.en && (mem_side || io_side);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> !hit);

  // R5
  io_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.io && !io_req) |-> !hit);

  // R5
  mem_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.io && !mem_req) |-> !hit);

  // R7
  periph_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.io && periph_hit) |-> !hit);

endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] grant
);

  logic [NCH:0] taken;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < NCH; i++) begin : g_chain
    assign grant[i]   = req[i] && !taken[i];
    assign taken[i+1] = taken[i] || req[i];
  end

  // R6
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> ($onehot0(grant) && ((grant & req) == grant) &&
                     ((req & (grant - 1'b1)) == '0) && grant != '0));

endmodule

// File: rtl/chip_sel_dec.sv
module chip_sel_dec
  import csd_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 24,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CFG_AW = CHW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_req,
  input  logic              io_req,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [NCH-1:0]    cs_n
);

  chan_cfg_t      cfg [NCH];
  logic [NCH-1:0] raw_hit;
  logic [NCH-1:0] grant;
  logic           periph_hit;

  assign periph_hit = in_periph_window(addr[15:0]);

  csd_cfg_regs #(.NCH(NCH)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    csd_chan_match #(.ADDR_W(ADDR_W)) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (cfg[i]),
      .addr       (addr),
      .mem_req    (mem_req),
      .io_req     (io_req),
      .periph_hit (periph_hit),
      .hit        (raw_hit[i])
    );
  end

  csd_prio #(.NCH(NCH)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (raw_hit),
    .grant (grant)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n <= '1;
    else        cs_n <= ~grant;
  end

  // R6
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R8
  select_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit == '0) |=> (cs_n == '1));

  // R7
  periph_io_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_hit && io_req && !mem_req) |=> (cs_n == '1));

endmodule

// File: tb/sim_chip_sel_dec.sv
module sim_chip_sel_dec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        mem_req = 1'b0;
  logic        io_req = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [3:0]  cs_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chip_sel_dec u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req), .io_req(io_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cs_n(cs_n)
  );

  task automatic chk(input logic [3:0] exp, input string tag);
    checks++;
    if (cs_n !== exp) begin
      errors++;
      $display("FAIL %s: cs_n=%b expected %b", tag, cs_n, exp);
    end
  endtask

  task automatic wr(input int ch, input int fld, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {ch[1:0], fld[1:0]}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input int ch, input bit en, input bit io,
                       input logic [7:0] lo, input logic [7:0] hi);
    wr(ch, 0, {6'd0, io, en});
    wr(ch, 1, lo);
    wr(ch, 2, hi);
  endtask

  // drive one cycle, then look one edge later
  task automatic cyc(input logic [23:0] a, input bit m, input bit i,
                     input logic [3:0] exp, input string tag);
    @(negedge clk);
    addr = a; mem_req = m; io_req = i;
    @(negedge clk);
    chk(exp, tag);
  endtask

  task automatic t_reset();
    cyc(24'h000000, 0, 0, 4'b1111, "R1 idle after reset");
    cyc(24'hFF1234, 1, 0, 4'b1110, "R1 ch0 full range");
    cyc(24'h3A0000, 1, 0, 4'b1110, "R1 others disabled");
  endtask

  task automatic t_mem_ranges();
    setup(0, 1, 0, 8'h00, 8'h7F);
    setup(1, 1, 0, 8'h80, 8'h9F);
    setup(2, 1, 0, 8'hA0, 8'hCF);
    setup(3, 1, 0, 8'hD1, 8'hFF);
    cyc(24'h7FFFFF, 1, 0, 4'b1110, "R3 ch0 upper edge");
    cyc(24'h800000, 1, 0, 4'b1101, "R3 ch1 lower edge");
    cyc(24'h9FFFFF, 1, 0, 4'b1101, "R3 ch1 upper edge");
    cyc(24'hA00000, 1, 0, 4'b1011, "R3 ch2 lower edge");
    cyc(24'hCFFFFF, 1, 0, 4'b1011, "R3 ch2 upper edge");
    cyc(24'hD0FFFF, 1, 0, 4'b1111, "R3 below ch3 lower");
    cyc(24'hD10000, 1, 0, 4'b0111, "R3 ch3 lower edge");
    cyc(24'h850000, 0, 0, 4'b1111, "R5 no mem strobe");
  endtask

  task automatic t_disable();
    wr(1, 0, 8'h00);
    cyc(24'h850000, 1, 0, 4'b1111, "R2 ch1 disabled");
    wr(1, 0, 8'h01);
    cyc(24'h850000, 1, 0, 4'b1101, "R2 ch1 re-enabled");
  endtask

  task automatic t_io();
    setup(2, 1, 1, 8'h12, 8'h00);
    cyc(24'hAB12CD, 0, 1, 4'b1011, "R4 io match ignores top byte");
    cyc(24'h001300, 0, 1, 4'b1111, "R4 io mismatch");
    cyc(24'h121200, 1, 0, 4'b1110, "R5 io channel ignores mem cycle");
    cyc(24'h901200, 0, 1, 4'b1011, "R5 mem channel ignores io cycle");
  endtask

  task automatic t_prio();
    setup(1, 1, 1, 8'h12, 8'h00);
    cyc(24'h001234, 0, 1, 4'b1101, "R6 ch1 beats ch2");
    setup(3, 1, 0, 8'h00, 8'hFF);
    cyc(24'h050000, 1, 0, 4'b1110, "R6 ch0 beats ch3");
    wr(0, 0, 8'h00);
    cyc(24'h050000, 1, 0, 4'b0111, "R6 ch3 once ch0 off");
  endtask

  task automatic t_window();
    setup(3, 1, 1, 8'h00, 8'h00);
    setup(1, 1, 1, 8'h01, 8'h00);
    cyc(24'h00007F, 0, 1, 4'b0111, "R7 007F outside window");
    cyc(24'h000080, 0, 1, 4'b1111, "R7 0080 blocked");
    cyc(24'hFF00FF, 0, 1, 4'b1111, "R7 00FF blocked any top byte");
    cyc(24'h000100, 0, 1, 4'b1101, "R7 0100 outside window");
  endtask

  task automatic t_latency();
    cyc(24'h000100, 0, 1, 4'b1101, "R8 setup");
    @(negedge clk);
    addr = 24'h00007F;
    #1 chk(4'b1101, "R8 holds between edges");
    @(negedge clk);
    chk(4'b0111, "R8 updates after edge");
  endtask

  task automatic t_spare();
    wr(3, 3, 8'h00);
    wr(1, 3, 8'hFF);
    cyc(24'h00007F, 0, 1, 4'b0111, "R9 spare write ignored ch3");
    cyc(24'h000100, 0, 1, 4'b1101, "R9 spare write ignored ch1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mem_ranges();
    t_disable();
    t_io();
    t_prio();
    t_window();
    t_latency();
    t_spare();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule